// File: doc/BRIEF.md
# Serial-In Shift Register with Output Latch

This block collects a serial bit stream in a shift chain and moves the whole chain in one step into a holding register. The holding register drives a parallel output bus. The chain advances on each rising edge of a shift strobe. A separate latch strobe loads the holding register. Because loading is a separate step, the parallel bus never shows a partly shifted word. The last chain stage also appears on a serial output, so several blocks can be chained to build a longer word.

Both strobes are level inputs that are synchronous to the system clock `clk`. The block finds their rising edges internally. A clear input empties the chain and leaves the holding register untouched. An active-low output enable decides whether the parallel bus is driven. Tri-state behaviour is modelled as a data bus plus a per-bit drive-enable vector, so the design needs no internal tri-state buffers. The pad ring or parent module turns that pair into real tri-state pins.

Top module: `sipo_latch_out`

## Requirements
- R1: A rising edge of `shift_stb` (sampled high at a `clk` edge after being low at the previous one) moves stage i to stage i+1 and loads `ser_in` into stage 0, at that same clock edge. `ser_out` always equals the last stage, so the first bit shifted in appears on `ser_out` after WIDTH shifts.
- R2: The chain keeps its contents at every clock edge without a shift-strobe rising edge. A strobe held high for several cycles shifts exactly once.
- R3: `rst` high at a clock edge clears every chain stage to 0, and it takes priority over a shift-strobe rising edge at that same edge.
- R4: `rst` does not change the holding register.
- R5: A rising edge of `latch_stb` copies all stages of the chain into the holding register in parallel. Chain stage i goes to holding bit i.
- R6: The holding register keeps its value at every clock edge without a latch-strobe rising edge, whatever the chain does.
- R7: When shift and latch rising edges fall on the same clock edge, the holding register takes the chain value from before that shift.
- R8: `pdata` and `pdrive` are registered one clock behind `out_en_n` and the holding register. With `out_en_n` low, `pdrive` is all ones and `pdata` equals the holding register. With `out_en_n` high, `pdrive` is all zeros and `pdata` is all zeros, which stands for high impedance.
- R9: `ser_out` does not depend on `out_en_n`. It follows the chain while the parallel bus is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge |
| rst | input | 1 | Synchronous active-high clear of the shift chain only |
| shift_stb | input | 1 | Shift strobe; its rising edge advances the chain |
| latch_stb | input | 1 | Latch strobe; its rising edge loads the holding register |
| ser_in | input | 1 | Serial data entering stage 0 |
| out_en_n | input | 1 | Active-low enable of the parallel bus |
| ser_out | output | 1 | Last chain stage, for cascading |
| pdata | output | WIDTH | Parallel data, zero while not driven |
| pdrive | output | WIDTH | Per-bit drive enable of the parallel bus |

## Verification
The chain, and therefore `ser_out`, changes at the clock edge where a strobe is first sampled high. The holding register also changes at that edge. `pdata` and `pdrive` change one edge later because of their output register. The bench drives inputs on falling edges. A behavioural queue model steps at each rising edge and is compared with the outputs at the next falling edge, so every sample lands after the edge that is meant to show a result. Directed checks pulse a strobe for one cycle and wait one more cycle before they read the parallel bus, which covers the extra stage.

// File: rtl/sipo_latch_pkg.sv
package sipo_latch_pkg;
  localparam int SR_DEF_WIDTH = 8;
  localparam int SR_NUM_STB   = 2;
  typedef enum logic {STB_SHIFT = 1'b0, STB_LATCH = 1'b1} stb_idx_e;
endpackage

// File: rtl/sr_edge_detect.sv
module sr_edge_detect #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic [N-1:0] lvl,
  output logic [N-1:0] rise
);
  logic [N-1:0] prev;

  for (genvar g = 0; g < N; g++) begin : g_stb
    always_ff @(posedge clk) prev[g] <= lvl[g];
    assign rise[g] = lvl[g] & ~prev[g];
  end
endmodule

// File: rtl/sr_shift_chain.sv
module sr_shift_chain #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  input  logic             din,
  output logic [WIDTH-1:0] chain
);
  localparam int TOP = WIDTH - 1;

  always_ff @(posedge clk) begin
    if (rst)       chain <= '0;
    else if (step) chain <= {chain[TOP-1:0], din};
  end

  AST_CHAIN_CLEAR: assert property (@(posedge clk) rst |=> (chain == '0)); // R3
  AST_CHAIN_IDLE: assert property (@(posedge clk) disable iff (rst)
    !step |=> $stable(chain)); // R2
  AST_CHAIN_ENTRY: assert property (@(posedge clk) disable iff (rst)
    step |=> (chain[0] == $past(din)) && (chain[TOP:1] == $past(chain[TOP-1:0]))); // R1
endmodule

// File: rtl/sr_hold_reg.sv
module sr_hold_reg #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [WIDTH-1:0] src,
  output logic [WIDTH-1:0] hold
);
  always_ff @(posedge clk) begin
    if (load) hold <= src;
  end

  AST_HOLD_KEEP: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(hold)); // R6
  AST_HOLD_COPY: assert property (@(posedge clk) disable iff (rst)
    load |=> (hold == $past(src))); // R5
endmodule

// File: rtl/sr_out_stage.sv
module sr_out_stage #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_n,
  input  logic [WIDTH-1:0] hold,
  output logic [WIDTH-1:0] pdata,
  output logic [WIDTH-1:0] pdrive
);
  always_ff @(posedge clk) begin
    if (en_n) begin
      pdata  <= '0;
      pdrive <= '0;
    end else begin
      pdata  <= hold;
      pdrive <= '1;
    end
  end

  AST_BUS_OFF: assert property (@(posedge clk) disable iff (rst)
    en_n |=> (pdrive == '0) && (pdata == '0)); // R8
  AST_BUS_ON: assert property (@(posedge clk) disable iff (rst)
    !en_n |=> (pdrive == '1) && (pdata == $past(hold))); // R8
endmodule

// File: rtl/sipo_latch_out.sv
module sipo_latch_out
  import sipo_latch_pkg::*;
#(
  parameter int WIDTH = SR_DEF_WIDTH
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             shift_stb,
  input  logic             latch_stb,
  input  logic             ser_in,
  input  logic             out_en_n,
  output logic             ser_out,
  output logic [WIDTH-1:0] pdata,
  output logic [WIDTH-1:0] pdrive
);
  logic [SR_NUM_STB-1:0] stb_lvl, stb_rise;
  logic [WIDTH-1:0]      chain, hold;

  assign stb_lvl[STB_SHIFT] = shift_stb;
  assign stb_lvl[STB_LATCH] = latch_stb;

  sr_edge_detect #(.N(SR_NUM_STB)) u_edges (
    .clk(clk), .lvl(stb_lvl), .rise(stb_rise));

  sr_shift_chain #(.WIDTH(WIDTH)) u_chain (
    .clk(clk), .rst(rst), .step(stb_rise[STB_SHIFT]), .din(ser_in), .chain(chain));

  sr_hold_reg #(.WIDTH(WIDTH)) u_hold (
    .clk(clk), .rst(rst), .load(stb_rise[STB_LATCH]), .src(chain), .hold(hold));

  sr_out_stage #(.WIDTH(WIDTH)) u_out (
    .clk(clk), .rst(rst), .en_n(out_en_n), .hold(hold), .pdata(pdata), .pdrive(pdrive));

  assign ser_out = chain[WIDTH-1];

  AST_SOUT_KEEP: assert property (@(posedge clk) disable iff (rst)
    !stb_rise[STB_SHIFT] |=> $stable(ser_out)); // R9
  AST_SAME_EDGE: assert property (@(posedge clk) disable iff (rst)
    (stb_rise[STB_SHIFT] && stb_rise[STB_LATCH]) |=> (hold == $past(chain))); // R7
endmodule

// File: tb/test_sipo_latch_out.sv
`timescale 1ns/1ps
module test_sipo_latch_out;
  localparam int W = 8;
  logic clk = 0, rst = 1, shift_stb = 0, latch_stb = 0, ser_in = 0, out_en_n = 1;
  logic ser_out;
  logic [W-1:0] pdata, pdrive;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  sipo_latch_out #(.WIDTH(W)) i_sipo_latch_out (
    .clk(clk), .rst(rst), .shift_stb(shift_stb), .latch_stb(latch_stb),
    .ser_in(ser_in), .out_en_n(out_en_n), .ser_out(ser_out),
    .pdata(pdata), .pdrive(pdrive));

  // behavioural reference
  bit chain_q[$];
  logic [W-1:0] m_hold = '0, m_data = '0, m_drive = '0;
  bit hold_known = 0, data_known = 0, chain_known = 0, bus_known = 0;
  bit p_s = 0, p_l = 0;

  function automatic logic [W-1:0] chain_vec();
    logic [W-1:0] v;
    for (int i = 0; i < W; i++) v[i] = chain_q[i];
    return v;
  endfunction

  initial for (int i = 0; i < W; i++) chain_q.push_back(1'b0);

  always @(posedge clk) begin
    bit rs, rl;
    rs = shift_stb && !p_s;
    rl = latch_stb && !p_l;
    bus_known = 1;
    if (out_en_n) begin m_data = '0; m_drive = '0; data_known = 1; end
    else begin m_data = m_hold; m_drive = '1; data_known = hold_known; end
    if (rl && chain_known) begin m_hold = chain_vec(); hold_known = 1; end
    if (rst) begin
      foreach (chain_q[i]) chain_q[i] = 1'b0;
      chain_known = 1;
    end else if (rs) begin
      chain_q.push_front(ser_in);
      void'(chain_q.pop_back());
    end
    p_s = shift_stb;
    p_l = latch_stb;
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (chain_known) chk("R1 ser_out vs model", ser_out, chain_q[W-1]);
    if (bus_known) chk("R8 pdrive vs model", pdrive, m_drive);
    if (bus_known && data_known) chk("R8 pdata vs model", pdata, m_data);
  end

  task automatic tick(); @(posedge clk); @(negedge clk); endtask
  task automatic pulse_shift(bit b);
    ser_in = b; shift_stb = 1; tick(); shift_stb = 0; tick();
  endtask
  task automatic pulse_latch();
    latch_stb = 1; tick(); latch_stb = 0; tick();
  endtask
  task automatic load_byte(logic [7:0] v);
    for (int i = W - 1; i >= 0; i--) pulse_shift(v[i]);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    @(negedge clk);
    tick(); tick();
    chk("R3 chain zero after clear", ser_out, 1'b0);
    chk("R8 bus off at reset", pdrive, '0);
    rst = 0;
    // R1: first bit reaches ser_out after W shifts
    load_byte(8'hA5);
    chk("R1 first bit at ser_out", ser_out, 1'b1);
    out_en_n = 0;
    pulse_latch();
    chk("R5 parallel copy", pdata, 8'hA5);
    chk("R8 bus driven", pdrive, 8'hFF);
    // R2: strobe held high shifts once
    ser_in = 1; shift_stb = 1; tick(); tick(); tick(); shift_stb = 0; tick();
    pulse_latch();
    chk("R2 single shift on long strobe", pdata, 8'h4B);
    // R6: shifting without latch leaves bus
    pulse_shift(0); pulse_shift(1); pulse_shift(1);
    chk("R6 hold unchanged by shifts", pdata, 8'h4B);
    // R3/R4: clear beats a shift edge and spares hold
    rst = 1; ser_in = 1; shift_stb = 1; tick(); rst = 0; shift_stb = 0; tick();
    chk("R3 clear priority ser_out", ser_out, 1'b0);
    chk("R4 hold survives clear", pdata, 8'h4B);
    pulse_latch();
    chk("R3 cleared chain latched", pdata, 8'h00);
    // R7: same-edge shift and latch
    pulse_shift(1);
    ser_in = 0; shift_stb = 1; latch_stb = 1; tick();
    shift_stb = 0; latch_stb = 0; tick();
    chk("R7 pre-shift value latched", pdata, 8'h01);
    pulse_latch();
    chk("R7 post-shift value", pdata, 8'h02);
    // R8/R9: disabled bus, serial path still live
    out_en_n = 1; tick();
    chk("R8 drive off", pdrive, 8'h00);
    chk("R8 data zero when off", pdata, 8'h00);
    for (int i = 0; i < 6; i++) pulse_shift(0);
    chk("R9 ser_out live while off", ser_out, 1'b1);
    pulse_shift(0);
    chk("R9 ser_out follows chain", ser_out, 1'b0);
    out_en_n = 0; tick();
    chk("R8 re-enable shows hold", pdata, 8'h02);
    // mixed pattern with the model comparing every cycle
    for (int i = 0; i < 40; i++) begin
      ser_in = i[0] ^ i[2];
      shift_stb = (i % 3) != 0;
      latch_stb = (i % 7) == 3;
      out_en_n = (i % 11) == 5;
      tick();
    end
    summary();
  end
endmodule